// File: doc/BRIEF.md
# Paired-Page Address Translator

This unit turns a virtual address into a physical one by searching a fully associative set of translation entries. The entries themselves live outside the block and are presented to it as a parallel read port. Each entry has four words: a page mask, a tag word, an even-half frame word and an odd-half frame word. One entry covers a pair of adjacent pages. The page mask sets the page size, starting at 4 KiB per half. One address bit, whose position depends on the mask, picks the even or the odd half. Each half has its own valid flag.

Requests come in on a valid/ready channel carrying the virtual address and a load/store flag. The result leaves one cycle after acceptance on a second valid/ready channel. The result carries exactly one of three outcome flags (hit, miss, invalid), the physical address and the load/store flag passed through unchanged. A downstream exception unit uses the load/store flag to tell load faults from store faults.

Back-pressure rules:
- A result is held, unchanged, while `rsp_ready` is low.
- `req_ready` is high only when the result register is empty or is being drained in the same cycle. A new request can therefore be accepted in the same cycle that the previous result leaves.
- The entry words are sampled only in the cycle a request is accepted.

Top module: `pgpair_xlate`

## Requirements
- R1: An entry matches when the virtual address and its tag word are equal on every bit set in the compare mask, where the compare mask = ~(page_mask | 0x1FFF). Tag bits outside the compare mask do not affect the match.
- R2: The half-select bit has the value ((page_mask >> 13) + 1) << 12. When the virtual address has that bit set, the odd frame word is used; otherwise the even frame word is used.
- R3: Bit 1 of the selected frame word is its valid flag. If the deciding entry's selected half has this bit clear, the result is invalid (`rsp_inval`=1), not a hit.
- R4: On a hit, `rsp_paddr` = 0x80000000 | ((frame << 6) & (cmask >> 1)) | (vaddr & ((page_mask | 0x1FFF) >> 1)), where cmask is the compare mask of R1. On a miss or an invalid result, `rsp_paddr` is 0.
- R5: When several entries match, the entry with the highest index decides the result, even if its selected half is invalid and a lower-indexed match is valid.
- R6: When no entry matches, the result is a miss (`rsp_miss`=1).
- R7: Every result asserts exactly one of `rsp_hit`, `rsp_miss` and `rsp_inval`.
- R8: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result is on the outputs with `rsp_valid` high after that same edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and all result outputs are held unchanged. Once `rsp_ready` goes high, a waiting request is accepted on that same edge.
- R10: `rsp_store` equals the `req_store` value of the request that produced the result.
- R11: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| ent_pmask | input | 32*NUM_ENT | Page mask word of each entry, entry i in bits [32i+31:32i] |
| ent_tag | input | 32*NUM_ENT | Tag word of each entry |
| ent_even | input | 32*NUM_ENT | Even-half frame word of each entry |
| ent_odd | input | 32*NUM_ENT | Odd-half frame word of each entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_inval | output | 1 | Deciding entry's half is not valid |
| rsp_paddr | output | 32 | Physical address (0 unless hit) |
| rsp_store | output | 1 | Access type of the request |

## Verification
The bench checks each of the following cases:
- Tag bits that lie under the page mask. A design that compared the full tag word would report a miss where R1 requires a hit.
- Address pairs that differ only in the half-select bit, for both the minimum page size and a 64 KiB page size. A design with a fixed select bit would return the wrong frame for the larger page.
- Overlapping entries, including a higher-indexed entry with an invalid half over a valid lower one. A design that preferred low indices, or skipped invalid matches, would report a hit there.
- A result held under back-pressure while a second request waits. A design that dropped or overwrote the held result would show a changed address, or lose the waiting request.

// File: rtl/pgpair_pkg.sv
package pgpair_pkg;
  localparam int unsigned XW       = 32;
  localparam int unsigned LO_SHIFT = 6;
  localparam int unsigned VBIT     = 1;
  localparam int unsigned MASK_LSB = 13;
  localparam int unsigned PAGE_LSB = 12;

  typedef logic [XW-1:0] word_t;

  localparam word_t MIN_OFS  = word_t'(32'h0000_1FFF);
  localparam word_t PA_BASE  = word_t'(32'h8000_0000);

  typedef enum logic [1:0] {
    XL_MISS  = 2'd0,
    XL_HIT   = 2'd1,
    XL_INVAL = 2'd2
  } xl_kind_t;

  typedef struct packed {
    xl_kind_t kind;
    word_t    pa;
  } xl_res_t;
endpackage

// File: rtl/pgpair_entry.sv
module pgpair_entry
  import pgpair_pkg::*;
(
  input  word_t va,
  input  word_t pmask,
  input  word_t tag,
  input  word_t lo_even,
  input  word_t lo_odd,
  output logic  match,
  output logic  half_ok,
  output word_t pa
);
  word_t ofs_mask;
  word_t cmp_mask;
  word_t half_bit;
  word_t frame;

  always_comb begin
    ofs_mask = pmask | MIN_OFS;
    cmp_mask = ~ofs_mask;
    half_bit = ((pmask >> MASK_LSB) + word_t'(1)) << PAGE_LSB;
    match    = ((va ^ tag) & cmp_mask) == '0;
    frame    = ((va & half_bit) != '0) ? lo_odd : lo_even;
    half_ok  = frame[VBIT];
    pa       = PA_BASE | ((frame << LO_SHIFT) & (cmp_mask >> 1)) | (va & (ofs_mask >> 1));
  end
endmodule

// File: rtl/pgpair_pick.sv
module pgpair_pick
  import pgpair_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] match_vec,
  input  logic [N-1:0] ok_vec,
  input  word_t        pa_arr [N],
  output xl_res_t      res
);
  always_comb begin
    res.kind = XL_MISS;
    res.pa   = '0;
    // ascending scan: the last (highest-index) match overrides earlier ones
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        if (ok_vec[i]) begin
          res.kind = XL_HIT;
          res.pa   = pa_arr[i];
        end else begin
          res.kind = XL_INVAL;
          res.pa   = '0;
        end
      end
    end
  end

  // R6: no candidate may only ever produce a miss
  always_comb begin
    if (match_vec == '0) begin
      a_r6_nomatch_miss: assert (res.kind == XL_MISS);
    end
  end
endmodule

// File: rtl/pgpair_xlate.sv
module pgpair_xlate
  import pgpair_pkg::*;
#(
  parameter int unsigned NUM_ENT = 32,
  localparam int unsigned FLAT_W = NUM_ENT * XW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XW-1:0]     req_vaddr,
  input  logic              req_store,
  input  logic [FLAT_W-1:0] ent_pmask,
  input  logic [FLAT_W-1:0] ent_tag,
  input  logic [FLAT_W-1:0] ent_even,
  input  logic [FLAT_W-1:0] ent_odd,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_inval,
  output logic [XW-1:0]     rsp_paddr,
  output logic              rsp_store
);
  logic [NUM_ENT-1:0] match_vec;
  logic [NUM_ENT-1:0] ok_vec;
  word_t              pa_arr [NUM_ENT];
  xl_res_t            res;
  logic               accept;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    pgpair_entry u_ent (
      .va      (req_vaddr),
      .pmask   (ent_pmask[g*XW +: XW]),
      .tag     (ent_tag[g*XW +: XW]),
      .lo_even (ent_even[g*XW +: XW]),
      .lo_odd  (ent_odd[g*XW +: XW]),
      .match   (match_vec[g]),
      .half_ok (ok_vec[g]),
      .pa      (pa_arr[g])
    );
  end

  pgpair_pick #(.N(NUM_ENT)) u_pick (
    .match_vec (match_vec),
    .ok_vec    (ok_vec),
    .pa_arr    (pa_arr),
    .res       (res)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_inval <= 1'b0;
      rsp_paddr <= '0;
      rsp_store <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= (res.kind == XL_HIT);
      rsp_miss  <= (res.kind == XL_MISS);
      rsp_inval <= (res.kind == XL_INVAL);
      rsp_paddr <= res.pa;
      rsp_store <= req_store;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_inval}) == 1);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_store)
                                   && $stable({rsp_hit, rsp_miss, rsp_inval})));

  a_r4_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

  a_r10_store: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_store == $past(req_store));

  a_r6_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && match_vec == '0) |=> rsp_miss);
endmodule

// File: tb/test_pgpair_xlate.sv
module test_pgpair_xlate;
  localparam int NE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_vaddr = '0;
  logic            req_store = 1'b0;
  logic [NE*32-1:0] f_pm, f_tag, f_ev, f_od;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic            rsp_hit, rsp_miss, rsp_inval, rsp_store;
  logic [31:0]     rsp_paddr;

  logic [31:0] pm [NE];
  logic [31:0] tg [NE];
  logic [31:0] ev [NE];
  logic [31:0] od [NE];

  int checks = 0;
  int fails  = 0;

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      f_pm[i*32 +: 32]  = pm[i];
      f_tag[i*32 +: 32] = tg[i];
      f_ev[i*32 +: 32]  = ev[i];
      f_od[i*32 +: 32]  = od[i];
    end
  end

  pgpair_xlate #(.NUM_ENT(NE)) i_pgpair_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .ent_pmask(f_pm), .ent_tag(f_tag), .ent_even(f_ev), .ent_odd(f_od),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_inval(rsp_inval),
    .rsp_paddr(rsp_paddr), .rsp_store(rsp_store)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected result computed from R1..R6
  task automatic model(input logic [31:0] va, output logic h, output logic m,
                       output logic iv, output logic [31:0] pa);
    logic found;
    logic [31:0] cm, sel, hb;
    found = 1'b0; h = 1'b0; m = 1'b1; iv = 1'b0; pa = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      cm = ~(pm[i] | 32'h1FFF);
      if (!found && (((va ^ tg[i]) & cm) == 32'h0)) begin
        found = 1'b1;
        m = 1'b0;
        hb = ((pm[i] >> 13) + 32'd1) << 12;
        sel = ((va & hb) != 0) ? od[i] : ev[i];
        if (sel[1]) begin
          h = 1'b1;
          pa = 32'h8000_0000 | ((sel << 6) & (cm >> 1)) | (va & ((pm[i] | 32'h1FFF) >> 1));
        end else begin
          iv = 1'b1;
        end
      end
    end
  endtask

  task automatic check_rsp(input string req, input logic [31:0] va, input logic st);
    logic h, m, iv;
    logic [31:0] pa;
    model(va, h, m, iv, pa);
    chk({req, " R8 valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " R7 hit"},   {31'd0, rsp_hit},   {31'd0, h});
    chk({req, " R6 miss"},  {31'd0, rsp_miss},  {31'd0, m});
    chk({req, " R3 inval"}, {31'd0, rsp_inval}, {31'd0, iv});
    chk({req, " R4 paddr"}, rsp_paddr, pa);
    chk({req, " R10 store"}, {31'd0, rsp_store}, {31'd0, st});
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic st);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(req, va, st);
  endtask

  task automatic clear_entries();
    for (int i = 0; i < NE; i++) begin
      pm[i] = '0; tg[i] = 32'hFFFF_E000; ev[i] = '0; od[i] = '0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_small_page();
    tg[5] = 32'h0040_0000 | 32'h0000_1ABC;  // R1: low tag bits are ignored
    ev[5] = 32'h0000_0402; od[5] = 32'h0000_0802;
    lookup("R1 even", 32'h0040_0123, 1'b0);
    chk("R4 even literal", rsp_paddr, 32'h8001_0123);
    lookup("R2 odd", 32'h0040_1456, 1'b1);
    chk("R2 odd literal", rsp_paddr, 32'h8002_0456);
  endtask

  task automatic t_invalid_half();
    tg[7] = 32'h0080_0000; ev[7] = 32'h0000_0400; od[7] = 32'h0000_0802;
    lookup("R3 even invalid", 32'h0080_0010, 1'b1);
    lookup("R3 odd valid", 32'h0080_1010, 1'b0);
  endtask

  task automatic t_big_page();
    pm[9] = 32'h0001_E000; tg[9] = 32'h0100_0000;
    ev[9] = 32'h0000_2002; od[9] = 32'h0000_4002;
    lookup("R2 big odd", 32'h0101_ABCD, 1'b0);
    chk("R4 big literal", rsp_paddr, 32'h8010_ABCD);
    lookup("R2 big even", 32'h0100_5000, 1'b0);  // bit 12 set, still even half
  endtask

  task automatic t_priority();
    tg[3]  = 32'h0200_0000; ev[3]  = 32'h0000_0C02;
    tg[20] = 32'h0200_0000; ev[20] = 32'h0000_1402;
    lookup("R5 high wins", 32'h0200_0044, 1'b0);
    tg[31] = 32'h0200_0000; ev[31] = 32'h0000_1800;
    lookup("R5 invalid high wins", 32'h0200_0044, 1'b0);
    chk("R5 inval flag", {31'd0, rsp_inval}, 32'd1);
  endtask

  task automatic t_miss();
    lookup("R6 miss", 32'h0300_0000, 1'b1);
    chk("R6 miss flag", {31'd0, rsp_miss}, 32'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'h0040_0123; req_store = 1'b1;
    @(negedge clk);
    check_rsp("R9 held A", 32'h0040_0123, 1'b1);
    req_vaddr = 32'h0080_1010; req_store = 1'b0;
    chk("R9 req_ready low", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    check_rsp("R9 still A", 32'h0040_0123, 1'b1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R9 then B", 32'h0080_1010, 1'b0);
    @(negedge clk);
    chk("R8 drained", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_entries();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_page();
    t_invalid_half();
    t_big_page();
    t_priority();
    t_miss();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule